// File: doc/BRIEF.md
# Multi-Channel Compare-Match Timer

This block holds several independent timer channels behind a plain word-addressed register port. Every channel has an up-counter, a compare register and a control/status register. All channels share one start/stop register, and each channel owns one bit in it. While a channel runs, a divide-by-8 prescaler steps its counter. When the count equals the compare value, the channel sets a sticky match flag. If clear-on-match is enabled, the counter also restarts from zero, so the compare value sets the period. A level interrupt per channel reports the match flag when the interrupt is enabled.

A parameter sets the counter width to 16 or 32 bits. The width decides where the flag pair sits in the control/status word and which control bits can be written.

The register address is `{channel, reg}`. The two low bits select the register:

| reg | Register |
|-----|----------|
| 0 | control/status (16 bits) |
| 1 | counter (32-bit access) |
| 2 | compare (32-bit access) |
| 3 | shared start/stop (16 bits), the same for any channel field |

Reads are combinational.

Each channel runs a two-state machine, HALT and COUNT.
- HALT to COUNT: a start/stop write with the channel's bit at 1 (transition START).
- COUNT to HALT: a start/stop write with that bit at 0 (transition STOP).
- Any other cycle: the state is kept.

In HALT the prescaler is held at zero and the counter does not move.

Top module: `cmt_timer`

## Requirements
- R1: After reset every channel is in HALT and the start/stop register reads 0. Counters and control words read 0, compare registers read all ones at the counter width, and every irq is low.
- R2: Bit c of the start/stop register (reg 3) is channel c's run state. A single write starts or stops any set of channels in the same cycle, and reading reg 3 returns the run bits.
- R3: A running channel's counter steps by one on the 8th clock edge after the START edge and every 8 edges after that. A halted channel's counter holds its value.
- R4: Control bits 2:0 are a clock-select field that is stored and read back, but every code gives divide-by-8.
- R5: On a step where the count equals the compare value, the match flag sets. If clear-on-match is on, the counter goes to 0 instead of incrementing, so the period is compare+1 steps. Clear-on-match is control bit 7 in the 32-bit variant and is always on in the 16-bit variant.
- R6: Flag positions depend on the width.
  - 32-bit variant: match flag at bit 15, wrap flag at bit 14.
  - 16-bit variant: match flag at bit 7, wrap flag at bit 6.
  - The wrap flag sets when the counter steps from all ones to zero without a match-clear.
- R7: Flags are sticky. A control write with a flag bit at 0 clears that flag, and a 1 leaves it unchanged, so software cannot set a flag. The other writable bits are stored as written and unwritable bits read 0. The writable masks are 0x01A7 (32-bit) and 0x0027 (16-bit).
- R8: irq[c] is high while channel c's match flag and its interrupt enable (control bit 5) are both set. It stays high until a control write clears the flag or the enable.
- R9: A counter write loads the counter directly. When it lands on a step cycle the written value wins, and stepping resumes from it.
- R10: A compare write while running takes effect at the next match check.
- R11: In the 32-bit variant, the control value 0x01A4 gives periodic clear-on-match operation with the interrupt enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | CH_W+2 | {channel, register select} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | NCH | Per-channel interrupt level |

## Verification
A fault in a channel's state machine shows in the start/stop readback one cycle after the write. It also freezes or releases the counter within 8 cycles. A prescaler phase error moves the first counter step off the 8th edge, which a counter read at edges 7 and 8 exposes. Compare or flag faults show on irq and in the control readback in the same cycle as the match step. The sticky and clear behaviour is visible at the next control read.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    typedef enum logic {
        CH_HALT  = 1'b0,
        CH_COUNT = 1'b1
    } ch_state_t;

    localparam logic [1:0] REG_CTRL  = 2'd0;
    localparam logic [1:0] REG_CNT   = 2'd1;
    localparam logic [1:0] REG_CMP   = 2'd2;
    localparam logic [1:0] REG_START = 2'd3;

    localparam int PRESCALE_W = 3;  // divide by 2**3 = 8
    localparam int CTRL_W     = 16;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
    parameter int DIV_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    logic [DIV_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    phase_q <= '0;
        else if (!run) phase_q <= '0;
        else           phase_q <= phase_q + 1'b1;
    end

    assign tick = run && (&phase_q);
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_we,
    input  logic              start_bit,
    input  logic              tick,
    input  logic              ctrl_we,
    input  logic              cnt_we,
    input  logic              cmp_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic [CW-1:0]     val_wdata,
    output logic              running,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [CW-1:0]     cnt_o,
    output logic [CW-1:0]     cmp_o,
    output logic              mflag_o,
    output logic              ie_o,
    output logic              clr_en_o,
    output logic              irq
);
    localparam int          FH        = (CW == 16) ? 7 : 15;
    localparam int          FL        = FH - 1;
    localparam logic [15:0] CTRL_MASK = (CW == 16) ? 16'h0027 : 16'h01A7;

    ch_state_t         st_q, st_d;
    logic [CTRL_W-1:0] ctrl_q;
    logic              mflag_q, wflag_q;
    logic [CW-1:0]     cnt_q, cmp_q;
    logic              clr_en, hit, wrap_ev;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_HALT;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_HALT:  if (start_we && start_bit)  st_d = CH_COUNT;
            CH_COUNT: if (start_we && !start_bit) st_d = CH_HALT;
        endcase
    end

    // state outputs
    always_comb begin
        running = 1'b0;
        unique case (st_q)
            CH_HALT:  running = 1'b0;
            CH_COUNT: running = 1'b1;
        endcase
    end

    generate
        if (CW == 16) begin : g_narrow
            assign clr_en = 1'b1;
        end else begin : g_wide
            assign clr_en = ctrl_q[7];
        end
    endgenerate

    assign hit     = tick && (cnt_q == cmp_q);
    assign wrap_ev = tick && (&cnt_q) && !(hit && clr_en);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            mflag_q <= 1'b0;
            wflag_q <= 1'b0;
            cnt_q   <= '0;
            cmp_q   <= '1;
        end else begin
            if (ctrl_we) ctrl_q <= ctrl_wdata & CTRL_MASK;
            mflag_q <= (mflag_q & ~(ctrl_we & ~ctrl_wdata[FH])) | hit;
            wflag_q <= (wflag_q & ~(ctrl_we & ~ctrl_wdata[FL])) | wrap_ev;
            if (cmp_we) cmp_q <= val_wdata;
            if (cnt_we)                cnt_q <= val_wdata;
            else if (hit && clr_en)    cnt_q <= '0;
            else if (tick)             cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        ctrl_o     = ctrl_q;
        ctrl_o[FH] = mflag_q;
        ctrl_o[FL] = wflag_q;
    end

    assign cnt_o    = cnt_q;
    assign cmp_o    = cmp_q;
    assign mflag_o  = mflag_q;
    assign ie_o     = ctrl_q[5];
    assign clr_en_o = clr_en;
    assign irq      = mflag_q && ctrl_q[5];
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int NCH = 2,
    parameter int CW  = 32,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int AW   = CH_W + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic [NCH-1:0] irq
);
    logic [CH_W-1:0] sel_ch;
    logic [1:0]      sel_reg;
    logic            start_we;

    logic [NCH-1:0]             run_vec, tick_vec, mflag_vec, ie_vec, clr_vec;
    logic [NCH-1:0]             ctrl_we_vec, cnt_we_vec, cmp_we_vec;
    logic [NCH-1:0][CTRL_W-1:0] ctrl_arr;
    logic [NCH-1:0][CW-1:0]     cnt_arr, cmp_arr;

    assign sel_ch   = bus_addr[AW-1:2];
    assign sel_reg  = bus_addr[1:0];
    assign start_we = bus_wr && (sel_reg == REG_START);

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic hit_sel;
            assign hit_sel        = bus_wr && (int'(sel_ch) == c);
            assign ctrl_we_vec[c] = hit_sel && (sel_reg == REG_CTRL);
            assign cnt_we_vec[c]  = hit_sel && (sel_reg == REG_CNT);
            assign cmp_we_vec[c]  = hit_sel && (sel_reg == REG_CMP);

            cmt_prescaler #(.DIV_W(PRESCALE_W)) u_pre (
                .clk  (clk),
                .rst_n(rst_n),
                .run  (run_vec[c]),
                .tick (tick_vec[c])
            );

            cmt_channel #(.CW(CW)) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .start_we  (start_we),
                .start_bit (bus_wdata[c]),
                .tick      (tick_vec[c]),
                .ctrl_we   (ctrl_we_vec[c]),
                .cnt_we    (cnt_we_vec[c]),
                .cmp_we    (cmp_we_vec[c]),
                .ctrl_wdata(bus_wdata[CTRL_W-1:0]),
                .val_wdata (bus_wdata[CW-1:0]),
                .running   (run_vec[c]),
                .ctrl_o    (ctrl_arr[c]),
                .cnt_o     (cnt_arr[c]),
                .cmp_o     (cmp_arr[c]),
                .mflag_o   (mflag_vec[c]),
                .ie_o      (ie_vec[c]),
                .clr_en_o  (clr_vec[c]),
                .irq       (irq[c])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (sel_reg == REG_START) begin
            bus_rdata = 32'(run_vec);
        end else if (int'(sel_ch) < NCH) begin
            unique case (sel_reg)
                REG_CTRL: bus_rdata = 32'(ctrl_arr[sel_ch]);
                REG_CNT:  bus_rdata = 32'(cnt_arr[sel_ch]);
                REG_CMP:  bus_rdata = 32'(cmp_arr[sel_ch]);
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk #(
    parameter int NCH = 2,
    parameter int CW  = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_we,
    input logic [31:0]            bus_wdata,
    input logic [NCH-1:0]         run_vec,
    input logic [NCH-1:0]         tick_vec,
    input logic [NCH-1:0]         mflag_vec,
    input logic [NCH-1:0]         clr_vec,
    input logic [NCH-1:0]         ctrl_we_vec,
    input logic [NCH-1:0]         cnt_we_vec,
    input logic [NCH-1:0][CW-1:0] cnt_arr,
    input logic [NCH-1:0][CW-1:0] cmp_arr,
    input logic [NCH-1:0]         irq
);
    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_we |=> (run_vec == $past(bus_wdata[NCH-1:0])));

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_c
            // R3
            halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!run_vec[c] && !cnt_we_vec[c]) |=> $stable(cnt_arr[c]));
            // R3
            first_cycle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(run_vec[c]) |-> !tick_vec[c]);
            // R5
            match_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (tick_vec[c] && clr_vec[c] && !cnt_we_vec[c] && (cnt_arr[c] == cmp_arr[c]))
                |=> ((cnt_arr[c] == '0) && mflag_vec[c]));
            // R7
            flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (mflag_vec[c] && !ctrl_we_vec[c]) |=> mflag_vec[c]);
            // R8
            irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (irq[c] && !ctrl_we_vec[c]) |=> irq[c]);
            // R9
            cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_we_vec[c] |=> (cnt_arr[c] == $past(bus_wdata[CW-1:0])));
        end
    endgenerate
endmodule

bind cmt_timer cmt_timer_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_we   (start_we),
    .bus_wdata  (bus_wdata),
    .run_vec    (run_vec),
    .tick_vec   (tick_vec),
    .mflag_vec  (mflag_vec),
    .clr_vec    (clr_vec),
    .ctrl_we_vec(ctrl_we_vec),
    .cnt_we_vec (cnt_we_vec),
    .cnt_arr    (cnt_arr),
    .cmp_arr    (cmp_arr),
    .irq        (irq)
);

// File: tb/sim_cmt_timer.sv
`timescale 1ns/1ps
module sim_cmt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr0 = 1'b0, wr1 = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic [1:0]  irq0, irq1;
    int          nchecks = 0;
    int          nerr = 0;

    always #2.5 clk = ~clk;

    cmt_timer #(.NCH(2), .CW(32)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr0), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata0), .irq(irq0));

    cmt_timer #(.NCH(2), .CW(16)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr1), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata1), .irq(irq1));

    localparam int RCTL = 0, RCNT = 1, RCMP = 2, RSTA = 3;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wreg(input int dut, input int ch, input int r, input logic [31:0] d);
        addr  = {ch[0], r[1:0]};
        wdata = d;
        if (dut == 0) wr0 = 1'b1; else wr1 = 1'b1;
        @(negedge clk);
        wr0 = 1'b0;
        wr1 = 1'b0;
    endtask

    task automatic rreg(input int dut, input int ch, input int r, output logic [31:0] v);
        addr = {ch[0], r[1:0]};
        #0.2;
        v = (dut == 0) ? rdata0 : rdata1;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int ch = 0; ch < 2; ch++) begin
            rreg(0, ch, RCTL, v); chk("R1 ctrl", v, 32'h0);
            rreg(0, ch, RCNT, v); chk("R1 cnt", v, 32'h0);
            rreg(0, ch, RCMP, v); chk("R1 cmp32", v, 32'hFFFF_FFFF);
        end
        rreg(1, 0, RCMP, v); chk("R1 cmp16", v, 32'h0000_FFFF);
        rreg(0, 0, RSTA, v); chk("R1 start", v, 32'h0);
        chk("R1 irq", {30'h0, irq0}, 32'h0);
    endtask

    task automatic t_prescale;
        logic [31:0] v;
        wreg(0, 0, RCMP, 32'd1000);
        wreg(0, 0, RCTL, 32'h0180);
        wreg(0, 0, RCNT, 32'h0);
        wreg(0, 0, RSTA, 32'h1);
        waitn(7);
        rreg(0, 0, RCNT, v); chk("R3 no step before 8th edge", v, 32'd0);
        waitn(1);
        rreg(0, 0, RCNT, v); chk("R3 first step", v, 32'd1);
        rreg(0, 0, RSTA, v); chk("R2 run bit read", v, 32'h1);
        rreg(0, 1, RCNT, v); chk("R2 other channel halted", v, 32'd0);
        waitn(8);
        rreg(0, 0, RCNT, v); chk("R3 second step", v, 32'd2);
        wreg(0, 0, RSTA, 32'h0);
        waitn(20);
        rreg(0, 0, RCNT, v); chk("R3 halted holds", v, 32'd2);
    endtask

    task automatic t_both;
        logic [31:0] v;
        wreg(0, 1, RCMP, 32'd1000);
        wreg(0, 1, RCTL, 32'h0180);
        wreg(0, 0, RSTA, 32'h3);
        waitn(8);
        rreg(0, 0, RCNT, v); chk("R2 ch0 runs", v, 32'd3);
        rreg(0, 1, RCNT, v); chk("R2 ch1 runs", v, 32'd1);
        wreg(0, 1, RSTA, 32'h0);
        rreg(0, 0, RSTA, v); chk("R2 both stopped", v, 32'h0);
    endtask

    task automatic t_cks;
        logic [31:0] v;
        wreg(0, 1, RCTL, 32'h0181);
        wreg(0, 1, RCNT, 32'h0);
        rreg(0, 1, RCTL, v); chk("R4 select stored", v, 32'h0181);
        wreg(0, 0, RSTA, 32'h2);
        waitn(7);
        rreg(0, 1, RCNT, v); chk("R4 still div8 edge7", v, 32'd0);
        waitn(1);
        rreg(0, 1, RCNT, v); chk("R4 still div8 edge8", v, 32'd1);
        wreg(0, 0, RSTA, 32'h0);
    endtask

    task automatic t_match;
        logic [31:0] v;
        wreg(0, 0, RCTL, 32'h0);
        wreg(0, 0, RCMP, 32'd2);
        wreg(0, 0, RCNT, 32'd0);
        wreg(0, 0, RCTL, 32'h01A4);
        wreg(0, 0, RSTA, 32'h1);
        waitn(23);
        rreg(0, 0, RCNT, v); chk("R5 reaches compare", v, 32'd2);
        chk("R11 no irq before match", {31'h0, irq0[0]}, 32'h0);
        waitn(1);
        rreg(0, 0, RCNT, v); chk("R5 restart at zero", v, 32'd0);
        rreg(0, 0, RCTL, v); chk("R11 match flag bit15", v, 32'h81A4);
        chk("R11 irq raised", {31'h0, irq0[0]}, 32'h1);
        waitn(8);
        rreg(0, 0, RCNT, v); chk("R5 periodic continues", v, 32'd1);
        wreg(0, 0, RSTA, 32'h0);
    endtask

    task automatic t_clear;
        logic [31:0] v;
        wreg(0, 0, RCTL, 32'h81A4);
        rreg(0, 0, RCTL, v); chk("R7 write 1 keeps flag", v, 32'h81A4);
        chk("R8 irq kept", {31'h0, irq0[0]}, 32'h1);
        wreg(0, 0, RCTL, 32'h01A4);
        rreg(0, 0, RCTL, v); chk("R7 write 0 clears flag", v, 32'h01A4);
        chk("R8 irq drops on clear", {31'h0, irq0[0]}, 32'h0);
        wreg(0, 0, RCTL, 32'h7E58);
        rreg(0, 0, RCTL, v); chk("R7 unwritable bits and no set", v, 32'h0);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        wreg(0, 0, RCTL, 32'h0180);
        wreg(0, 0, RCMP, 32'd0);
        wreg(0, 0, RCNT, 32'd0);
        wreg(0, 0, RSTA, 32'h1);
        waitn(8);
        wreg(0, 0, RSTA, 32'h0);
        rreg(0, 0, RCTL, v); chk("R8 flag without enable", v, 32'h8180);
        chk("R8 irq low when disabled", {31'h0, irq0[0]}, 32'h0);
        wreg(0, 0, RCTL, 32'h81A0);
        chk("R8 irq on enable", {31'h0, irq0[0]}, 32'h1);
        wreg(0, 0, RCTL, 32'h0);
        chk("R8 irq off", {31'h0, irq0[0]}, 32'h0);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        wreg(0, 0, RCMP, 32'd5);
        wreg(0, 0, RCNT, 32'hFFFF_FFFE);
        wreg(0, 0, RSTA, 32'h1);
        waitn(8);
        rreg(0, 0, RCNT, v); chk("R6 near wrap", v, 32'hFFFF_FFFF);
        waitn(8);
        rreg(0, 0, RCNT, v); chk("R6 wrapped", v, 32'd0);
        rreg(0, 0, RCTL, v); chk("R6 wrap flag bit14", v, 32'h4000);
        wreg(0, 0, RSTA, 32'h0);
        wreg(0, 0, RCTL, 32'h0);
    endtask

    task automatic t_narrow;
        logic [31:0] v;
        wreg(1, 0, RCTL, 32'h0020);
        wreg(1, 0, RCMP, 32'd1);
        wreg(1, 0, RCNT, 32'd0);
        wreg(1, 0, RSTA, 32'h1);
        waitn(16);
        rreg(1, 0, RCNT, v); chk("R6 16-bit restart", v, 32'd0);
        rreg(1, 0, RCTL, v); chk("R6 16-bit match flag bit7", v, 32'h00A0);
        chk("R6 16-bit irq", {31'h0, irq1[0]}, 32'h1);
        wreg(1, 0, RSTA, 32'h0);
        wreg(1, 0, RCTL, 32'h0020);
        wreg(1, 0, RCMP, 32'd5);
        wreg(1, 0, RCNT, 32'h0000_FFFF);
        wreg(1, 0, RSTA, 32'h1);
        waitn(8);
        rreg(1, 0, RCNT, v); chk("R6 16-bit wrap count", v, 32'd0);
        rreg(1, 0, RCTL, v); chk("R6 16-bit wrap flag bit6", v, 32'h0060);
        chk("R8 wrap gives no irq", {31'h0, irq1[0]}, 32'h0);
        wreg(1, 0, RSTA, 32'h0);
        wreg(1, 0, RCTL, 32'h01A4);
        rreg(1, 0, RCTL, v); chk("R7 16-bit mask", v, 32'h0024);
    endtask

    task automatic t_cntwr;
        logic [31:0] v;
        wreg(0, 0, RCTL, 32'h0180);
        wreg(0, 0, RCMP, 32'd1000);
        wreg(0, 0, RCNT, 32'd0);
        wreg(0, 0, RSTA, 32'h1);
        waitn(7);
        wreg(0, 0, RCNT, 32'd50);
        rreg(0, 0, RCNT, v); chk("R9 write beats step", v, 32'd50);
        waitn(8);
        rreg(0, 0, RCNT, v); chk("R9 steps from written value", v, 32'd51);
        wreg(0, 0, RSTA, 32'h0);
    endtask

    task automatic t_cmp;
        logic [31:0] v;
        wreg(0, 0, RCTL, 32'h0180);
        wreg(0, 0, RCMP, 32'd100);
        wreg(0, 0, RCNT, 32'd0);
        wreg(0, 0, RSTA, 32'h1);
        waitn(24);
        rreg(0, 0, RCNT, v); chk("R10 before rewrite", v, 32'd3);
        wreg(0, 0, RCMP, 32'd4);
        waitn(14);
        rreg(0, 0, RCNT, v); chk("R10 reaches new compare", v, 32'd4);
        rreg(0, 0, RCTL, v); chk("R10 no flag yet", v, 32'h0180);
        waitn(1);
        rreg(0, 0, RCNT, v); chk("R10 new compare matched", v, 32'd0);
        rreg(0, 0, RCTL, v); chk("R10 flag set", v, 32'h8180);
        wreg(0, 0, RSTA, 32'h0);
    endtask

    initial begin
        #(200000 * 5);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prescale();
        t_both();
        t_cks();
        t_match();
        t_clear();
        t_irq();
        t_wrap();
        t_narrow();
        t_cntwr();
        t_cmp();
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end
endmodule